// File: doc/BRIEF.md
# Stepped Current-Limit Soft-Start Sequencer

This block raises the current-limit setting of a boost converter in equal steps once the LED drive is enabled. The setting is a small integer code that starts at one ninth of full scale and climbs by one ninth per step until it reaches nine ninths. The code then stays at full scale. An analog comparator outside this block turns the code into a peak-current threshold.

Each step has a minimum interval, counted in ticks from an external 1 ms tick generator (two ticks by default). A step is also held back until the LED strings have conducted at least once since the previous step. At low dimming duty and a low dimming frequency, the ramp therefore waits for conduction and never runs ahead of a load that is not drawing current. Taking enable low holds the sequencer at its starting point. Raising enable again starts a fresh ramp.

Top module: `ilim_softstart`

## Requirements
- R1: While `enable` is low, `ilim_code` is 1 and `ss_done` is 0 from the first clock edge that samples `enable` low. Conduction pulses and ticks in that time have no effect.
- R2: On the cycle `enable` is first seen high, `ilim_code` is 1. A ramp always begins at the one-ninth level.
- R3: A step raises `ilim_code` by exactly 1. It cannot occur until `TICKS_PER_STEP` ticks (default 2) have been sampled since the previous step or since enable.
- R4: Once the tick interval has elapsed, a step occurs only after a conduction pulse. The step is taken on the clock edge after the edge that samples `led_on` high, so the new code is visible one cycle after that pulse.
- R5: Conduction seen in one interval is used up by the step that closes it. It does not allow the next step.
- R6: `ilim_code` never exceeds 9 (`STEPS`+1). `ss_done` is 1 exactly when `ilim_code` is 9 and stays 1 while enable remains high.
- R7: Taking `enable` low and then high again restarts the ramp at code 1. Ticks and conduction from before the disable do not count toward the first step.
- R8: A synchronous active-high `rst` puts the block in the state `ilim_code` = 1, `ss_done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | LED drive enable; low holds and re-arms the ramp |
| led_on | input | 1 | High in any cycle in which an LED string conducts |
| tick_1ms | input | 1 | One-cycle pulse per millisecond |
| ilim_code | output | 4 | Current-limit code, 1 (one ninth) to 9 (full) |
| ss_done | output | 1 | High when the code has reached full scale |

## Verification
Every result is one register away from the input that causes it. A tick or conduction pulse sampled at edge E updates an internal counter or flag at E. The step is taken at edge E+1, so the new code is visible one cycle after the last enabling input. A low `enable` forces the code to 1 at the edge that samples it. The bench drives inputs at falling edges and, for each scenario, waits the number of falling edges these register stages require before sampling. For the conduction-gated step it samples both the cycle before and the cycle after the step, which pins the step to a single edge.

// File: rtl/ilim_ss_pkg.sv
package ilim_ss_pkg;

  // Phase of the ramp as kept by the level stepper.
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,   // disabled or first enabled cycle
    PH_RAMP = 2'd1,   // stepping toward full scale
    PH_FULL = 2'd2    // full scale reached
  } ramp_phase_e;

  // Width needed to hold the top code STEPS+1.
  function automatic int code_width(input int steps);
    return $clog2(steps + 2);
  endfunction

endpackage

// File: rtl/ilim_ss_interval.sv
module ilim_ss_interval #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic elapsed
);
  localparam int CW = (TICKS < 1) ? 1 : $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(TICKS);

  logic [CW-1:0] cnt;

  // Saturating tick counter; a clear drops any tick in the same cycle.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick && (cnt != LIM)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign elapsed = (cnt == LIM);

endmodule

// File: rtl/ilim_ss_conduct.sv
module ilim_ss_conduct (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic led_on,
  output logic seen
);
  // Sticky record of conduction; clearing takes priority over setting.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen <= 1'b0;
    end else if (led_on) begin
      seen <= 1'b1;
    end
  end

endmodule

// File: rtl/ilim_ss_stepper.sv
module ilim_ss_stepper
  import ilim_ss_pkg::*;
#(
  parameter int STEPS  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              advance,
  output logic [CODE_W-1:0] code,
  output logic              done
);
  localparam logic [CODE_W-1:0] CODE_START = CODE_W'(1);
  localparam logic [CODE_W-1:0] CODE_TOP   = CODE_W'(STEPS + 1);

  ramp_phase_e       phase;
  logic [CODE_W-1:0] code_inc;

  assign code_inc = code + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      code  <= CODE_START;
      phase <= PH_HOLD;
    end else begin
      unique case (phase)
        PH_HOLD: phase <= PH_RAMP;
        PH_RAMP: begin
          if (advance) begin
            code <= code_inc;
            if (code_inc == CODE_TOP) phase <= PH_FULL;
          end
        end
        PH_FULL: phase <= PH_FULL;
        default: phase <= PH_HOLD;
      endcase
    end
  end

  assign done = (phase == PH_FULL);

endmodule

// File: rtl/ilim_softstart.sv
module ilim_softstart
  import ilim_ss_pkg::*;
#(
  parameter int STEPS          = 8,
  parameter int TICKS_PER_STEP = 2,
  parameter int CODE_W         = code_width(STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              led_on,
  input  logic              tick_1ms,
  output logic [CODE_W-1:0] ilim_code,
  output logic              ss_done
);
  logic interval_up;
  logic conducted;
  logic step_now;
  logic rearm;

  // A step needs an elapsed interval and conduction since the last step.
  assign step_now = enable && interval_up && conducted && !ss_done;
  assign rearm    = !enable || step_now;

  ilim_ss_interval #(
    .TICKS (TICKS_PER_STEP)
  ) u_interval (
    .clk     (clk),
    .rst     (rst),
    .clear   (rearm),
    .tick    (tick_1ms),
    .elapsed (interval_up)
  );

  ilim_ss_conduct u_conduct (
    .clk    (clk),
    .rst    (rst),
    .clear  (rearm),
    .led_on (led_on),
    .seen   (conducted)
  );

  ilim_ss_stepper #(
    .STEPS  (STEPS),
    .CODE_W (CODE_W)
  ) u_stepper (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .advance (step_now),
    .code    (ilim_code),
    .done    (ss_done)
  );

endmodule

// File: rtl/ilim_softstart_chk.sv
module ilim_softstart_chk #(
  parameter int STEPS          = 8,
  parameter int TICKS_PER_STEP = 2,
  parameter int CODE_W         = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              led_on,
  input logic              tick_1ms,
  input logic [CODE_W-1:0] ilim_code,
  input logic              ss_done
);
  localparam int CW = $clog2(TICKS_PER_STEP + 2);
  localparam logic [CW-1:0] LIM = CW'(TICKS_PER_STEP);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(STEPS + 1);

  logic [CODE_W-1:0] prev_code;
  logic [CW-1:0]     tick_seen;
  logic              cond_seen;
  logic              changed;

  assign changed = (ilim_code != prev_code);

  // Window counter and conduction record since the last observed code change.
  always_ff @(posedge clk) begin
    prev_code <= ilim_code;
    if (rst || !enable || changed) begin
      tick_seen <= (enable && !rst && tick_1ms) ? CW'(1) : '0;
      cond_seen <= enable && !rst && led_on;
    end else begin
      if (tick_1ms && tick_seen != LIM) tick_seen <= tick_seen + 1'b1;
      if (led_on) cond_seen <= 1'b1;
    end
  end

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (ilim_code == CODE_W'(1) && !ss_done));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |-> (ilim_code == CODE_W'(1)));

  assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ilim_code != $past(ilim_code)) |->
      (ilim_code == $past(ilim_code) + 1'b1 || ilim_code == CODE_W'(1)));

  assert_interval_met_R3: assert property (@(posedge clk) disable iff (rst)
    (changed && ilim_code != CODE_W'(1)) |-> (tick_seen >= LIM));

  assert_conducted_R4: assert property (@(posedge clk) disable iff (rst)
    (changed && ilim_code != CODE_W'(1)) |-> cond_seen);

  assert_code_range_R6: assert property (@(posedge clk) disable iff (rst)
    (ilim_code >= CODE_W'(1)) && (ilim_code <= TOP));

  assert_done_at_top_R6: assert property (@(posedge clk) disable iff (rst)
    ss_done == (ilim_code == TOP));

endmodule

bind ilim_softstart ilim_softstart_chk #(
  .STEPS          (STEPS),
  .TICKS_PER_STEP (TICKS_PER_STEP),
  .CODE_W         (CODE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .led_on    (led_on),
  .tick_1ms  (tick_1ms),
  .ilim_code (ilim_code),
  .ss_done   (ss_done)
);

// File: tb/ilim_softstart_test.sv
module ilim_softstart_test;
  localparam int STEPS  = 8;
  localparam int TICKS  = 2;
  localparam int CODE_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enable = 1'b0;
  logic              led_on = 1'b0;
  logic              tick_1ms = 1'b0;
  logic [CODE_W-1:0] ilim_code;
  logic              ss_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ilim_softstart #(
    .STEPS          (STEPS),
    .TICKS_PER_STEP (TICKS),
    .CODE_W         (CODE_W)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .led_on    (led_on),
    .tick_1ms  (tick_1ms),
    .ilim_code (ilim_code),
    .ss_done   (ss_done)
  );

  task automatic expect_state(input string req, input int code_exp, input int done_exp);
    checks++;
    if (int'(ilim_code) != code_exp || int'(ss_done) != done_exp) begin
      errors++;
      $display("FAIL %s: actual code=%0d done=%0d expected code=%0d done=%0d",
               req, ilim_code, ss_done, code_exp, done_exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_pulse();
    @(negedge clk) tick_1ms = 1'b1;
    @(negedge clk) tick_1ms = 1'b0;
  endtask

  task automatic conduct_pulse();
    @(negedge clk) led_on = 1'b1;
    @(negedge clk) led_on = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; enable = 1'b1;
    idle(3);
    expect_state("R8 reset state", 1, 0);
    rst = 1'b0; enable = 1'b0;
    idle(1);
  endtask

  task automatic t_disabled();
    conduct_pulse();
    for (int i = 0; i < 3; i++) tick_pulse();
    conduct_pulse();
    idle(2);
    expect_state("R1 disabled ignores ticks and conduction", 1, 0);
  endtask

  task automatic t_enable_start();
    @(negedge clk) enable = 1'b1;
    idle(2);
    expect_state("R2 first level after enable", 1, 0);
  endtask

  task automatic t_interval();
    conduct_pulse();
    tick_pulse();
    idle(3);
    expect_state("R3 no step before interval", 1, 0);
    tick_pulse();
    idle(2);
    expect_state("R3 step after interval", 2, 0);
  endtask

  task automatic t_postpone();
    tick_pulse();
    tick_pulse();
    idle(6);
    expect_state("R5 old conduction not reused", 2, 0);
    @(negedge clk) led_on = 1'b1;
    @(negedge clk) led_on = 1'b0;
    expect_state("R4 step not yet taken", 2, 0);
    @(negedge clk);
    expect_state("R4 step one cycle after conduction", 3, 0);
  endtask

  task automatic t_ramp();
    for (int k = 4; k <= STEPS + 1; k++) begin
      conduct_pulse();
      tick_pulse();
      tick_pulse();
      idle(2);
      expect_state("R6 ramp level", k, (k == STEPS + 1) ? 1 : 0);
    end
    conduct_pulse();
    tick_pulse();
    tick_pulse();
    idle(3);
    expect_state("R6 saturates at full scale", STEPS + 1, 1);
  endtask

  task automatic t_restart();
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    expect_state("R1 disable forces start level", 1, 0);
    @(negedge clk) enable = 1'b1;
    conduct_pulse();
    tick_pulse();
    @(negedge clk) enable = 1'b0;
    idle(2);
    @(negedge clk) enable = 1'b1;
    idle(1);
    expect_state("R7 restart at start level", 1, 0);
    conduct_pulse();
    tick_pulse();
    idle(3);
    expect_state("R7 ticks before disable discarded", 1, 0);
    tick_pulse();
    idle(2);
    expect_state("R7 first step of new ramp", 2, 0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_enable_start();
    t_interval();
    t_postpone();
    t_ramp();
    t_restart();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule